// File: doc/BRIEF.md
# Microcoded Bit-Bang I2C Sequencer

This block is an I2C master that carries no knowledge of bytes, addresses or acknowledges. Software fills a small program store with step words. Each step word sets the level of SCL and SDA, says whether SDA is to be sampled, and names the step that follows. A start command walks the linked steps and holds each step's pin levels for a programmable number of clock cycles. The walk ends when it reaches a step whose busy flag is clear. That step's levels are then held on the pins while the block sits idle. Bits sampled on the way are shifted into a 32-bit result register, so a short register read can be collected without a byte engine.

Both pins are open-drain. The block only decides when to pull each line low, and it reads the SDA line back through `sda_in`. Start, stop, data and acknowledge phases are all expressed as sequences of steps. Location 0 is kept as the parked idle step. A run therefore begins at location 1 and normally ends with a step whose next address is 0.

Top module: `i2c_microseq`

## Requirements
- R1: A word on `prog_word` is stored when `prog_we` is high. The store location is bits [18 +: ADDR_W]. Bit 13 is the busy flag. Bit 12 requests a sample. Bit 11 set pulls SCL low and clear releases it. Bit 10 set pulls SDA low and clear releases it. Bits [ADDR_W-1:0] give the next step address.
- R2: After reset, `busy` is 0, both lines are released and `result` is 0.
- R3: A `start` pulse while idle begins execution at location 1, and `busy` is high from the next cycle. A `start` pulse while busy has no effect on the pins, the run length or `result`.
- R4: Every executed step with its busy flag set drives its SCL and SDA levels for exactly `step_len` clock cycles. `busy` stays high for the total of those cycles.
- R5: After a step ends, execution follows that step's next address. On reaching a step with the busy flag clear, `busy` drops and that step's levels stay on the pins until the next start.
- R6: A step with the sample bit set captures `sda_in` in its last cycle and shifts it into bit 0 of `result`, moving the older bits up. After more than 32 samples only the latest 32 remain, so the last byte read lands in bits [7:0].
- R7: Accepting a start clears `result` to 0.
- R8: If location 1 has its busy flag clear, a start never raises `busy` and leaves that step's levels on the pins.
- R9: A `step_len` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Program store write enable |
| prog_word | input | 32 | Step word with store location, flags and next address |
| start | input | 1 | Run command, taken only while idle |
| step_len | input | LEN_W | Clock cycles per step (0 acts as 1) |
| busy | output | 1 | High while a program runs |
| result | output | RES_W | Shift register of sampled SDA bits |
| scl_drive_low | output | 1 | Pull SCL low (open-drain enable) |
| sda_drive_low | output | 1 | Pull SDA low (open-drain enable) |
| sda_in | input | 1 | Level read back from the SDA line |

## Verification
The bench uses the default parameters: a 1024-entry store with 10-bit step addresses, a 16-bit step length and a 32-bit result. This lets it fill the whole store, as an initialising driver would, and place programs of more than a hundred steps. Step lengths of 0, 1, 3 and 5 are short enough to check the pin level in every step of each program. A 36-bit read goes past the width of the result register and shows that the oldest bits are discarded.

// File: rtl/i2cseq_pkg.sv
// Package: shared step-word field positions and the decoded pin/flag record.
// Assumes the step store location field starts at bit 18 of a 32-bit word.
package i2cseq_pkg;
    localparam int POS_LOC_LSB = 18;
    localparam int POS_BUSY    = 13;
    localparam int POS_SAMPLE  = 12;
    localparam int POS_SCL_LOW = 11;
    localparam int POS_SDA_LOW = 10;
    localparam int FLAG_W      = 4;

    typedef struct packed {
        logic busy;
        logic sample;
        logic scl_low;
        logic sda_low;
    } step_flags_t;

    localparam step_flags_t FLAGS_RELEASED = '{busy: 1'b0, sample: 1'b0,
                                               scl_low: 1'b0, sda_low: 1'b0};
endpackage

// File: rtl/i2cseq_store.sv
// Program store: DEPTH entries of flags plus next address, one write port
// and one combinational read port. Assumes software fills every entry it uses.
module i2cseq_store #(
    parameter int ADDR_W = 10,
    parameter int ENT_W  = ADDR_W + 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ENT_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ENT_W-1:0] mem [DEPTH];

    // write one step entry
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // read the entry at the requested address
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/i2cseq_timer.sv
// Step timer: counts the cycles of the current step and flags the last one.
// Assumes step_len stays constant while a run is in progress.
module i2cseq_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [LEN_W-1:0] step_len,
    output logic             last
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_eff;

    // zero length acts as one cycle per step
    always_comb len_eff = (step_len == '0) ? LEN_W'(1) : step_len;

    // last cycle of the step, robust against a shrinking length
    always_comb last = run && (cnt >= len_eff - LEN_W'(1));

    // cycle counter within the current step
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart || last) cnt <= '0;
        else if (run)            cnt <= cnt + LEN_W'(1);
    end

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt == '0));

    p_step_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step_len <= LEN_W'(1)) |-> last);
endmodule

// File: rtl/i2cseq_shift.sv
// Result shifter: clears on request and otherwise shifts a sampled bit into
// the LSB. Assumes clear and shift are never needed in the same cycle.
module i2cseq_shift #(
    parameter int RES_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [RES_W-1:0] value
);
    // clear or shift the collected bits
    always_ff @(posedge clk) begin
        if (!rst_n)        value <= '0;
        else if (clear)    value <= '0;
        else if (shift_en) value <= {value[RES_W-2:0], bit_in};
    end

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (value == '0));

    p_lsb_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clear) |=> (value[0] == $past(bit_in)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear) |=> $stable(value));
endmodule

// File: rtl/i2c_microseq.sv
// Top: walks linked step words from location 1, drives open-drain SCL/SDA
// from the current step, samples SDA on flagged steps and parks on the first
// step with busy clear. Assumes ADDR_W <= 10 so the next-address field does
// not overlap the flag bits, and no clock stretching by the target.
module i2c_microseq #(
    parameter int ADDR_W     = 10,
    parameter int LEN_W      = 16,
    parameter int RES_W      = 32,
    parameter int START_ADDR = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic [31:0]      prog_word,
    input  logic             start,
    input  logic [LEN_W-1:0] step_len,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    input  logic             sda_in
);
    import i2cseq_pkg::*;

    localparam int ENT_W = ADDR_W + FLAG_W;

    logic              busy_q;
    step_flags_t       cur_flags;
    logic [ADDR_W-1:0] cur_next;
    logic [ADDR_W-1:0] rd_addr;
    logic [ENT_W-1:0]  rd_ent;
    logic [ENT_W-1:0]  wr_ent;
    step_flags_t       fetch_flags;
    logic [ADDR_W-1:0] fetch_next;
    logic              step_last;
    logic              accept;
    logic              unused_bits;

    // pack the written word into a store entry
    always_comb begin
        wr_ent = {prog_word[POS_BUSY], prog_word[POS_SAMPLE],
                  prog_word[POS_SCL_LOW], prog_word[POS_SDA_LOW],
                  prog_word[ADDR_W-1:0]};
    end
    assign unused_bits = ^{prog_word[31:POS_LOC_LSB+ADDR_W], prog_word[17:14]};

    // choose which entry to look at: first step when idle, successor when running
    always_comb rd_addr = busy_q ? cur_next : ADDR_W'(START_ADDR);

    i2cseq_store #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_store (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_word[POS_LOC_LSB +: ADDR_W]),
        .wdata (wr_ent),
        .raddr (rd_addr),
        .rdata (rd_ent)
    );

    // split the fetched entry
    always_comb begin
        fetch_flags = step_flags_t'(rd_ent[ADDR_W +: FLAG_W]);
        fetch_next  = rd_ent[ADDR_W-1:0];
    end

    assign accept = start && !busy_q;

    i2cseq_timer #(.LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q),
        .restart  (accept),
        .step_len (step_len),
        .last     (step_last)
    );

    i2cseq_shift #(.RES_W(RES_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (busy_q && step_last && cur_flags.sample),
        .bit_in   (sda_in),
        .value    (result)
    );

    // sequencer: load first step on start, advance at the end of each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cur_flags <= FLAGS_RELEASED;
            cur_next  <= '0;
        end else if (accept || (busy_q && step_last)) begin
            busy_q    <= fetch_flags.busy;
            cur_flags <= fetch_flags;
            cur_next  <= fetch_next;
        end
    end

    // pins follow the current step
    always_comb begin
        busy          = busy_q;
        scl_drive_low = cur_flags.scl_low;
        sda_drive_low = cur_flags.sda_low;
    end

    p_rise_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start));

    p_pins_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !step_last) |=> $stable({scl_drive_low, sda_drive_low}));

    p_parked_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !cur_flags.busy);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> $stable({scl_drive_low, sda_drive_low}));
endmodule

// File: tb/test_i2c_microseq.sv
// Directed bench: builds step programs, runs them and checks every step's pins.
module test_i2c_microseq;
    localparam int LEN_W = 16;
    localparam int MAXS  = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prog_we = 1'b0;
    logic [31:0]      prog_word = '0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] step_len = 16'd3;
    logic             busy;
    logic [31:0]      result;
    logic             scl_drive_low;
    logic             sda_drive_low;
    logic             sda_in = 1'b1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic exp_scl_low [MAXS];
    logic exp_sda_low [MAXS];
    logic slave_bit   [MAXS];
    int   nsteps;

    always #2 clk = ~clk;

    i2c_microseq i_i2c_microseq (
        .clk (clk), .rst_n (rst_n), .prog_we (prog_we), .prog_word (prog_word),
        .start (start), .step_len (step_len), .busy (busy), .result (result),
        .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
        .sda_in (sda_in)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int loc, input bit bsy, input bit smp,
                       input bit scl_hi, input bit sda_hi, input int nxt);
        prog_word = (32'(loc) << 18) | (32'(bsy) << 13) | (32'(smp) << 12) |
                    (32'(!scl_hi) << 11) | (32'(!sda_hi) << 10) | 32'(nxt);
        prog_we = 1'b1;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    // append a busy step at location nsteps+1
    task automatic emit(input bit smp, input bit scl_hi, input bit sda_hi,
                        input bit sbit, input bit last);
        put(nsteps + 1, 1'b1, smp, scl_hi, sda_hi, last ? 0 : nsteps + 2);
        exp_scl_low[nsteps] = !scl_hi;
        exp_sda_low[nsteps] = !sda_hi;
        slave_bit[nsteps]   = sbit;
        nsteps++;
    endtask

    task automatic start_cond;
        emit(0, 1, 1, 1, 0); emit(0, 1, 0, 1, 0); emit(0, 0, 0, 1, 0);
    endtask
    task automatic stop_cond;
        emit(0, 0, 0, 1, 0); emit(0, 1, 0, 1, 0); emit(0, 1, 1, 1, 1);
    endtask
    task automatic wbit(input bit b);
        emit(0, 0, b, 1, 0); emit(0, 1, b, 1, 0); emit(0, 0, b, 1, 0);
    endtask
    task automatic rbit(input bit b);
        emit(0, 0, 1, b, 0); emit(0, 1, 1, b, 0); emit(1, 1, 1, b, 0); emit(0, 0, 1, b, 0);
    endtask

    // run the loaded program, checking pins and busy in every step (R4, R5)
    task automatic run_prog(input logic [LEN_W-1:0] len, input bit poke, input string tag);
        int L;
        int bad;
        L = (len == 0) ? 1 : int'(len);
        step_len = len;
        bad = 0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < nsteps; i++) begin
            sda_in = slave_bit[i] & !exp_sda_low[i];
            if (scl_drive_low !== exp_scl_low[i] || sda_drive_low !== exp_sda_low[i] || busy !== 1'b1) begin
                bad++;
                $display("FAIL %s step %0d actual scl_low=%b sda_low=%b busy=%b expected %b %b 1",
                         tag, i, scl_drive_low, sda_drive_low, busy, exp_scl_low[i], exp_sda_low[i]);
            end
            if (poke && i == 2) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                repeat (L - 1) @(negedge clk);
            end else begin
                repeat (L) @(negedge clk);
            end
        end
        checks++;
        if (bad != 0) fails++;
        sda_in = 1'b1;
        chk({tag, " R5 parked busy/pins"}, {busy, scl_drive_low, sda_drive_low}, 3'b000);
    endtask

    task automatic t_reset;
        chk("R2 reset busy", busy, 0);
        chk("R2 reset pins", {scl_drive_low, sda_drive_low}, 2'b00);
        chk("R2 reset result", result, 0);
    endtask

    task automatic t_write_byte;
        nsteps = 0;
        start_cond();
        for (int k = 7; k >= 0; k--) wbit(bit'((8'h5A >> k) & 1));
        wbit(1'b1);
        stop_cond();
        run_prog(16'd3, 1'b0, "R1 R4 write 0x5A len3");
        chk("R7 result after write-only run", result, 0);
    endtask

    task automatic t_read_byte;
        nsteps = 0;
        for (int k = 7; k >= 0; k--) rbit(bit'((8'hA5 >> k) & 1));
        stop_cond();
        run_prog(16'd5, 1'b0, "R4 read len5");
        chk("R6 read byte", result, 32'h0000_00A5);
    endtask

    task automatic t_read_long;
        logic [35:0] pat;
        pat = 36'h9_DEAD_BEEF;
        nsteps = 0;
        for (int k = 35; k >= 0; k--) rbit(pat[k]);
        stop_cond();
        run_prog(16'd1, 1'b0, "R4 read36 len1");
        chk("R6 read 36 keeps last 32", result, 32'hDEAD_BEEF);
    endtask

    task automatic t_start_ignored;
        nsteps = 0;
        for (int k = 15; k >= 0; k--) rbit(bit'((16'h3C96 >> k) & 1));
        stop_cond();
        run_prog(16'd3, 1'b1, "R3 start during run");
        chk("R3 result not cleared by busy start", result, 32'h0000_3C96);
    endtask

    task automatic t_zero_len;
        nsteps = 0;
        start_cond();
        wbit(1'b0);
        wbit(1'b1);
        stop_cond();
        run_prog(16'd0, 1'b0, "R9 zero length");
    endtask

    task automatic t_park_first;
        put(1, 1'b0, 1'b0, 1'b1, 1'b0, 1);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy never rises", busy, 0);
        chk("R8 parked levels", {scl_drive_low, sda_drive_low}, 2'b01);
        chk("R7 result cleared by start", result, 0);
        repeat (4) @(negedge clk);
        chk("R8 still parked", {busy, scl_drive_low, sda_drive_low}, 3'b001);
        put(1, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int a = 0; a < 1024; a++) put(a, 1'b0, 1'b0, 1'b1, 1'b1, 0);
        chk("R1 idle fill keeps pins released", {busy, scl_drive_low, sda_drive_low}, 3'b000);
        t_write_byte();
        t_read_byte();
        t_read_long();
        t_park_first();
        t_start_ignored();
        t_zero_len();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule